// File: doc/BRIEF.md
# Real-Time-Clock Prescaler with Stop Gating

This block divides the 32.768 kHz clock of a real-time clock into the pulses that the rest of the clock uses. It is clocked directly by the 32.768 kHz source. A free-running front stage produces a 1024 Hz tick and a 4096 Hz tick. A gated back chain produces 64 Hz ticks, second ticks, minute ticks and hour ticks. Every tick is a single-cycle pulse in the 32.768 kHz domain. A timer-source selector picks one of these ticks for a wakeup timer. A frequency-output selector drives one of three square waves, or drives the pin low.

A stop input halts timekeeping. While it is high, the back chain below 1024 Hz is held cleared. Seconds, minutes, hours, the update event and the alarm event all go quiet. The 32.768 kHz and 1024 Hz outputs and the 4096 Hz timer tick keep running. When stop is released, the chain starts from zero phase, so the first second after release is a full second.

Two sticky status flags are also held here. One records a loss of oscillation or retained data. The other records a reset-level voltage detection. Software clears each flag by writing 0 to it.

Top module: `rtc_prescaler`

## Requirements
- R1: `tick_1024` pulses once every HF_DIV clocks, on the last count of the front divider, and keeps doing so while `stop` is high. `tmr_src` code 000 pulses once every K4096_DIV clocks, also regardless of `stop`.
- R2: With `stop` low, the back chain counts as follows. `tick_64` pulses on every F64_DIV-th `tick_1024`. `tick_sec` pulses on every SEC_DIV-th `tick_64`. `tick_min` pulses on every SEC_PER_MIN-th `tick_sec`. `tick_hr` pulses on every MIN_PER_HR-th `tick_min`. A slower tick only falls in the same cycle as the faster ticks that complete it.
- R3: A clock edge with `stop` high clears the back chain. After release, the first `tick_sec` comes on the F64_DIV*SEC_DIV-th `tick_1024` that follows.
- R4: While `stop` is high, `tick_64`, `tick_sec`, `tick_min`, `tick_hr`, `upd_evt` and `alarm_evt` stay low.
- R5: `tmr_tick` follows `tmr_src` as follows: 000 gives the 4096 Hz tick, 001 gives `tick_64`, 010 gives `tick_sec`, 011 gives `tick_min`, 100 gives `tick_hr`, and 101 to 111 give no pulses.
- R6: `fout` follows `fout_sel` as follows. 00 drives it low. 01 passes the clock through. 10 gives the 1024 Hz square, high during the upper half of the front divider count. 11 gives the 1 Hz square, high while the second-stage count is in its upper half. The 1 Hz square is low from the first clock edge with `stop` high until release.
- R7: `upd_evt` equals `tick_sec` when `upd_sel` is 0 and `tick_min` when `upd_sel` is 1. `alarm_evt` is `alarm_hit` qualified by `tick_sec`.
- R8: `vlf` sets on `vlf_event` and holds until a write with `flag_wr` high and `flag_wdata[0]` = 0. Writing 1 has no effect. An event in the same cycle as a clearing write leaves the flag set.
- R9: `rsf` behaves like `vlf`, using `rsf_event` and `flag_wdata[1]`.
- R10: While `rst_n` is low, all counters and both flags are zero, and every tick output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop | input | 1 | Halt timekeeping when high |
| fout_sel | input | 2 | Frequency output select |
| tmr_src | input | 3 | Wakeup timer source select |
| upd_sel | input | 1 | Update event period: 0 second, 1 minute |
| alarm_hit | input | 1 | Alarm compare match from the calendar |
| vlf_event | input | 1 | Oscillation or data loss detected |
| rsf_event | input | 1 | Reset-level voltage detected |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Flag write data: bit 0 vlf, bit 1 rsf |
| tick_1024 | output | 1 | 1024 Hz tick |
| tick_64 | output | 1 | 64 Hz tick |
| tick_sec | output | 1 | Second tick for timekeeping |
| tick_min | output | 1 | Minute tick |
| tick_hr | output | 1 | Hour tick |
| tmr_tick | output | 1 | Selected timer source tick |
| fout | output | 1 | Frequency output |
| upd_evt | output | 1 | Time-update interrupt event |
| alarm_evt | output | 1 | Alarm interrupt event |
| vlf | output | 1 | Sticky loss flag |
| rsf | output | 1 | Sticky reset-detect flag |

## Verification
The bench builds the block with HF_DIV=4, K4096_DIV=2, F64_DIV=2, SEC_DIV=4, SEC_PER_MIN=3 and MIN_PER_HR=2, so an hour lasts 192 clocks. With these values a run of a few thousand clocks passes through many minute and hour rollovers, stop windows of 1, 3, 30 and 200 clocks, and every code of both selectors. The two flags are swept over every combination of prior state, event, write strobe and write data.

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int HF_DIV      = 32,
  parameter int K4096_DIV   = 8,
  parameter int F64_DIV     = 16,
  parameter int SEC_DIV     = 64,
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_PER_HR  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop,
  input  logic [1:0] fout_sel,
  input  logic [2:0] tmr_src,
  input  logic       upd_sel,
  input  logic       alarm_hit,
  input  logic       vlf_event,
  input  logic       rsf_event,
  input  logic       flag_wr,
  input  logic [1:0] flag_wdata,
  output logic       tick_1024,
  output logic       tick_64,
  output logic       tick_sec,
  output logic       tick_min,
  output logic       tick_hr,
  output logic       tmr_tick,
  output logic       fout,
  output logic       upd_evt,
  output logic       alarm_evt,
  output logic       vlf,
  output logic       rsf
);
  localparam int HW = $clog2(HF_DIV);
  localparam int KW = $clog2(K4096_DIV);
  localparam int FW = $clog2(F64_DIV);
  localparam int SW = $clog2(SEC_DIV);
  localparam int MW = $clog2(SEC_PER_MIN);
  localparam int RW = $clog2(MIN_PER_HR);

  logic [HW-1:0] hf_q;
  logic [KW-1:0] k4_q;
  logic [FW-1:0] f64_q;
  logic [SW-1:0] s_q;
  logic [MW-1:0] m_q;
  logic [RW-1:0] r_q;
  logic          tick_4k;

  assign tick_1024 = hf_q == HW'(HF_DIV - 1);
  assign tick_4k   = k4_q == KW'(K4096_DIV - 1);
  assign tick_64   = tick_1024 & ~stop & (f64_q == FW'(F64_DIV - 1));
  assign tick_sec  = tick_64 & (s_q == SW'(SEC_DIV - 1));
  assign tick_min  = tick_sec & (m_q == MW'(SEC_PER_MIN - 1));
  assign tick_hr   = tick_min & (r_q == RW'(MIN_PER_HR - 1));

  assign upd_evt   = upd_sel ? tick_min : tick_sec;
  assign alarm_evt = alarm_hit & tick_sec;

  always_comb begin
    case (tmr_src)
      3'd0:    tmr_tick = tick_4k;
      3'd1:    tmr_tick = tick_64;
      3'd2:    tmr_tick = tick_sec;
      3'd3:    tmr_tick = tick_min;
      3'd4:    tmr_tick = tick_hr;
      default: tmr_tick = 1'b0;
    endcase
  end

  always_comb begin
    case (fout_sel)
      2'd1:    fout = clk;
      2'd2:    fout = hf_q >= HW'(HF_DIV / 2);
      2'd3:    fout = s_q >= SW'(SEC_DIV / 2);
      default: fout = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hf_q  <= '0;
      k4_q  <= '0;
      f64_q <= '0;
      s_q   <= '0;
      m_q   <= '0;
      r_q   <= '0;
      vlf   <= 1'b0;
      rsf   <= 1'b0;
    end else begin
      hf_q <= tick_1024 ? '0 : hf_q + 1'b1;
      k4_q <= tick_4k ? '0 : k4_q + 1'b1;
      if (stop) begin
        f64_q <= '0;
        s_q   <= '0;
        m_q   <= '0;
        r_q   <= '0;
      end else begin
        if (tick_1024) f64_q <= tick_64  ? '0 : f64_q + 1'b1;
        if (tick_64)   s_q   <= tick_sec ? '0 : s_q + 1'b1;
        if (tick_sec)  m_q   <= tick_min ? '0 : m_q + 1'b1;
        if (tick_min)  r_q   <= tick_hr  ? '0 : r_q + 1'b1;
      end
      vlf <= vlf_event | (vlf & ~(flag_wr & ~flag_wdata[0]));
      rsf <= rsf_event | (rsf & ~(flag_wr & ~flag_wdata[1]));
    end
  end

  // R4
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !tick_64 && !tick_sec && !upd_evt && !alarm_evt);
  // R2
  min_in_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_min |-> tick_sec && tick_64 && tick_1024);
  // R2
  hr_in_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_hr |-> tick_min);
  // R3
  release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop) |-> !tick_sec && !tick_min);
  // R6
  fout_1hz_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop && $past(stop) && fout_sel == 2'd3 |-> !fout);
  // R8
  vlf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vlf && !(flag_wr && !flag_wdata[0]) |=> vlf);
  // R8
  vlf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vlf_event |=> vlf);
  // R9
  rsf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsf && !(flag_wr && !flag_wdata[1]) |=> rsf);
  // R9
  rsf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsf_event |=> rsf);
endmodule

// File: tb/rtc_prescaler_bench.sv
`timescale 1ns/1ps
module rtc_prescaler_bench;
  localparam int D1K = 4, D4K = 2, D64 = 2, DS = 4, SPM = 3, MPH = 2;
  localparam int NCYC = 2500;

  logic clk = 1'b0, rst_n = 1'b0, stop = 1'b0, upd_sel = 1'b0, alarm_hit = 1'b0;
  logic vlf_event = 1'b0, rsf_event = 1'b0, flag_wr = 1'b0;
  logic [1:0] fout_sel = 2'd0, flag_wdata = 2'd0;
  logic [2:0] tmr_src = 3'd0;
  logic tick_1024, tick_64, tick_sec, tick_min, tick_hr, tmr_tick, fout;
  logic upd_evt, alarm_evt, vlf, rsf;

  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_prescaler #(.HF_DIV(D1K), .K4096_DIV(D4K), .F64_DIV(D64), .SEC_DIV(DS),
                  .SEC_PER_MIN(SPM), .MIN_PER_HR(MPH)) u_rtc_prescaler (
    .clk, .rst_n, .stop, .fout_sel, .tmr_src, .upd_sel, .alarm_hit,
    .vlf_event, .rsf_event, .flag_wr, .flag_wdata,
    .tick_1024, .tick_64, .tick_sec, .tick_min, .tick_hr, .tmr_tick, .fout,
    .upd_evt, .alarm_evt, .vlf, .rsf);

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit stop_at(int i);
    return (i >= 400 && i < 430) || (i >= 700 && i < 703) || i == 1000 ||
           (i >= 1500 && i < 1700);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int cyc, k;
    bit rel_pending;
    bit e1k, e64, esec, emin, ehr, e4k, etmr, efout, prev_stop;
    int c64, cs, cm, cr;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10", "tick_1024", tick_1024, 1'b0);
    chk("R10", "tick_sec", tick_sec, 1'b0);
    chk("R10", "tmr_tick", tmr_tick, 1'b0);
    chk("R10", "vlf", vlf, 1'b0);
    chk("R10", "rsf", rsf, 1'b0);
    chk("R10", "fout", fout, 1'b0);
    rst_n = 1'b1;
    cyc = 0; k = 0; rel_pending = 0; prev_stop = 0;
    for (int i = 0; i < NCYC; i++) begin
      @(posedge clk);
      if (stop) k = 0;
      else if (cyc % D1K == D1K - 1) k++;
      cyc++;
      #1;
      if (fout_sel == 2'd1) chk("R6", "fout clk high", fout, 1'b1);
      @(negedge clk);
      c64 = k % D64; cs = (k / D64) % DS; cm = (k / (D64 * DS)) % SPM;
      cr = (k / (D64 * DS * SPM)) % MPH;
      e1k  = (cyc % D1K) == D1K - 1;
      e4k  = (cyc % D4K) == D4K - 1;
      e64  = e1k && !stop && c64 == D64 - 1;
      esec = e64 && cs == DS - 1;
      emin = esec && cm == SPM - 1;
      ehr  = emin && cr == MPH - 1;
      case (tmr_src)
        3'd0: etmr = e4k;
        3'd1: etmr = e64;
        3'd2: etmr = esec;
        3'd3: etmr = emin;
        3'd4: etmr = ehr;
        default: etmr = 1'b0;
      endcase
      case (fout_sel)
        2'd2: efout = (cyc % D1K) >= D1K / 2;
        2'd3: efout = cs >= DS / 2;
        default: efout = 1'b0;
      endcase
      chk("R1", "tick_1024", tick_1024, e1k);
      chk("R2", "tick_64", tick_64, e64);
      chk(rel_pending ? "R3" : "R2", "tick_sec", tick_sec, esec);
      chk("R2", "tick_min", tick_min, emin);
      chk("R2", "tick_hr", tick_hr, ehr);
      chk("R5", "tmr_tick", tmr_tick, etmr);
      chk("R6", "fout", fout, efout);
      chk("R7", "upd_evt", upd_evt, upd_sel ? emin : esec);
      chk("R7", "alarm_evt", alarm_evt, alarm_hit && esec);
      if (stop) begin
        chk("R4", "tick_sec stopped", tick_sec, 1'b0);
        chk("R4", "alarm_evt stopped", alarm_evt, 1'b0);
        chk("R4", "upd_evt stopped", upd_evt, 1'b0);
        if (prev_stop && fout_sel == 2'd3) chk("R6", "1Hz fout stopped", fout, 1'b0);
      end
      if (esec) rel_pending = 0;
      prev_stop = stop;
      stop = stop_at(i + 1);
      if (prev_stop && !stop) rel_pending = 1;
      fout_sel  = 2'((i / 37) % 4);
      tmr_src   = 3'((i / 53) % 8);
      upd_sel   = ((i / 97) % 2) == 1;
      alarm_hit = (i % 3) == 0;
    end
    stop = 1'b0;
    // R8 R9 exhaustive flag sweep
    for (int f = 0; f < 2; f++) begin
      for (int c = 0; c < 16; c++) begin
        bit prev, ev, wr, wd, expv;
        prev = c[3]; ev = c[2]; wr = c[1]; wd = c[0];
        @(negedge clk);
        flag_wr = 1'b1; flag_wdata = 2'b00;
        if (prev) begin
          flag_wr = 1'b0;
          if (f == 0) vlf_event = 1'b1; else rsf_event = 1'b1;
        end
        @(negedge clk);
        vlf_event = 1'b0; rsf_event = 1'b0;
        if (f == 0) vlf_event = ev; else rsf_event = ev;
        flag_wr = wr;
        flag_wdata = wd ? 2'b11 : 2'b00;
        @(negedge clk);
        vlf_event = 1'b0; rsf_event = 1'b0; flag_wr = 1'b0;
        expv = ev | (prev & ~(wr & ~wd));
        if (f == 0) chk("R8", "vlf", vlf, expv);
        else        chk("R9", "rsf", rsf, expv);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule